// File: doc/BRIEF.md
# Stereo Smooth Volume Ramp

This block applies a per-channel gain to a stereo stream of signed sample words, one left and one right word per audio frame, each frame marked by a one-cycle strobe. The gain is never applied in a single step. Each channel keeps an actual 10-bit level that moves by at most one code per frame toward its requested level. Each sample is multiplied by that actual level and divided by 1024. Code 0x3FF is exact unity gain. Walking the level slowly avoids audible clicks when the volume changes.

Muting goes through the same ramp. A mute pin and a mute control bit are ORed together. While either is high, both channels ramp toward code 0. When both are low, each channel ramps back to its stored request. Each channel also has a zero flag. The flag rises when that channel has received only all-zero samples for more than 1024 consecutive frames. A hard reset or a soft power-down clears every datapath register.

Top module: `stereo_vol_ramp`

## Requirements
- R1: After reset (rst_n low), or in the cycle after pwr_down is sampled high, both levels, both outputs and both zero counts are 0. So the outputs read 0 and the flags read low.
- R2: At each clock edge where frame_stb is high, each channel's actual level moves one code toward its effective target, or stays put if it already equals the target. Without a strobe, the levels and outputs do not change.
- R3: The request inputs are sampled only at a strobe edge. A request change that is withdrawn before the next strobe has no effect.
- R4: When the actual level is 0x3FF, the output word equals the input word exactly.
- R5: At other levels, the output is floor(in × level / 1024), computed as a signed multiply followed by an arithmetic shift. The level used is the one held before that strobe's update. The result appears on the output in the cycle after the strobe edge.
- R6: If mute_pin or mute_bit is high, the effective target of both channels is 0. Once both are low, the target returns to the stored request and the level ramps back.
- R7: A channel's zero flag goes high after its 1025th consecutive all-zero sample. It goes low in the cycle after any nonzero sample on that channel.
- R8: The zero count saturates and does not wrap, so the flag stays high for as long as all-zero samples keep arriving.
- R9: The two channels ramp independently. A full swing between 0 and 0x3FF takes 1023 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Soft power-down; clears datapath registers |
| frame_stb | input | 1 | One-cycle strobe per stereo frame |
| left_in | input | DATA_W | Left sample, two's complement |
| right_in | input | DATA_W | Right sample, two's complement |
| req_left | input | LVL_W | Requested left level, 0x3FF = unity |
| req_right | input | LVL_W | Requested right level |
| mute_pin | input | 1 | Mute from pin |
| mute_bit | input | 1 | Mute from control bit |
| left_out | output | DATA_W | Attenuated left sample |
| right_out | output | DATA_W | Attenuated right sample |
| zero_left | output | 1 | Left long-silence flag |
| zero_right | output | 1 | Right long-silence flag |

## Verification
The bench walks the level through every code from 0 to 0x3FF, then back down, using extreme input words including the most negative value. This catches a scaler that treats 0x3FF as 1023/1024, a scaler that rounds negative products toward zero, or a design that uses the already-updated level. The zero flag is probed at exactly 1024 and 1025 zero frames and then held for thousands of frames. An off-by-one threshold would show up in the first probe, and a wrapping counter would drop the flag in the second. Mute is applied from each source separately and released partway through a ramp, so a design that jumped to the target, or that muted only one channel, would disagree with the frame-by-frame model.

// File: rtl/svr_pkg.sv
// Shared types for the stereo volume ramp.
package svr_pkg;
    // Direction chosen by a level ramp on a frame strobe
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_t;
endpackage

// File: rtl/svr_level_ramp.sv
// Moves an actual level one code per frame toward the request, or toward
// zero while muted. Assumes frame_stb is a single-cycle pulse.
module svr_level_ramp
    import svr_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             frame_stb,
    input  logic [LVL_W-1:0] req,
    input  logic             mute,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] target;
    ramp_dir_t        dir;

    // Pick the effective target and the step direction
    always_comb begin
        target = mute ? '0 : req;
        if (target > level)      dir = DIR_UP;
        else if (target < level) dir = DIR_DOWN;
        else                     dir = DIR_HOLD;
    end

    // Step the actual level once per frame
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            level <= '0;
        end else if (frame_stb) begin
            case (dir)
                DIR_UP:   level <= level + 1'b1;
                DIR_DOWN: level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !pwr_down) |=> $stable(level)); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !pwr_down) |=> (level == $past(level)
            || level == LVL_W'($past(level) + 1'b1)
            || level == LVL_W'($past(level) - 1'b1))); // R2
    AST_MUTE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !pwr_down && mute && level != '0)
            |=> level == LVL_W'($past(level) - 1'b1)); // R6
    AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> level == '0); // R1
endmodule

// File: rtl/svr_scaler.sv
// Registers in * level / 2^LVL_W on each frame strobe; the all-ones level is
// exact unity. Assumes level is the pre-update value for this frame.
module svr_scaler #(
    parameter int DATA_W = 24,
    parameter int LVL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [LVL_W-1:0]  level,
    output logic [DATA_W-1:0] sample_out
);
    localparam int PROD_W = DATA_W + LVL_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic        [DATA_W-1:0] scaled;

    // Signed multiply by the unsigned level and arithmetic shift
    always_comb begin
        prod    = PROD_W'($signed(sample_in)) * $signed({1'b0, level});
        shifted = prod >>> LVL_W;
        scaled  = (level == '1) ? sample_in : shifted[DATA_W-1:0];
    end

    // Capture the scaled word on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) sample_out <= '0;
        else if (frame_stb)     sample_out <= scaled;
    end

    AST_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !pwr_down && level == '1) |=> sample_out == $past(sample_in)); // R4
    AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !pwr_down && level == '0) |=> sample_out == '0); // R5
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !pwr_down) |=> $stable(sample_out)); // R2
endmodule

// File: rtl/svr_zero_detect.sv
// Counts consecutive all-zero samples per frame and saturates; the flag is
// high once the count exceeds ZERO_FRAMES.
module svr_zero_detect #(
    parameter int DATA_W      = 24,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] sample_in,
    output logic              zero_flag
);
    localparam int SAT   = ZERO_FRAMES + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [CNT_W-1:0] cnt;

    // Count zero frames, clear on signal, stop at the saturation value
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            cnt <= '0;
        end else if (frame_stb) begin
            if (sample_in != '0)          cnt <= '0;
            else if (cnt != CNT_W'(SAT))  cnt <= cnt + 1'b1;
        end
    end

    assign zero_flag = (cnt == CNT_W'(SAT));

    AST_CLEAR_ON_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && sample_in != '0) |=> !zero_flag); // R7
    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && !pwr_down && (!frame_stb || sample_in == '0)) |=> zero_flag); // R8
endmodule

// File: rtl/stereo_vol_ramp.sv
// Stereo attenuator with per-frame level ramp, shared mute and zero flags.
// Assumes one frame_stb pulse per stereo frame carrying both samples.
module stereo_vol_ramp #(
    parameter int DATA_W      = 24,
    parameter int LVL_W       = 10,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    input  logic [LVL_W-1:0]  req_left,
    input  logic [LVL_W-1:0]  req_right,
    input  logic              mute_pin,
    input  logic              mute_bit,
    output logic [DATA_W-1:0] left_out,
    output logic [DATA_W-1:0] right_out,
    output logic              zero_left,
    output logic              zero_right
);
    localparam int NCH = 2;

    logic              mute;
    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];
    logic [LVL_W-1:0]  ch_req [NCH];
    logic [LVL_W-1:0]  ch_lvl [NCH];
    logic              ch_zero[NCH];

    // Either mute source silences both channels
    assign mute = mute_pin | mute_bit;

    assign ch_in[0]  = left_in;
    assign ch_in[1]  = right_in;
    assign ch_req[0] = req_left;
    assign ch_req[1] = req_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        svr_level_ramp #(.LVL_W(LVL_W)) u_ramp (
            .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
            .frame_stb(frame_stb), .req(ch_req[c]), .mute(mute),
            .level(ch_lvl[c])
        );
        svr_scaler #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_scale (
            .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
            .frame_stb(frame_stb), .sample_in(ch_in[c]),
            .level(ch_lvl[c]), .sample_out(ch_out[c])
        );
        svr_zero_detect #(.DATA_W(DATA_W), .ZERO_FRAMES(ZERO_FRAMES)) u_zero (
            .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
            .frame_stb(frame_stb), .sample_in(ch_in[c]),
            .zero_flag(ch_zero[c])
        );
    end

    assign left_out   = ch_out[0];
    assign right_out  = ch_out[1];
    assign zero_left  = ch_zero[0];
    assign zero_right = ch_zero[1];

    AST_PD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (left_out == '0 && right_out == '0 && !zero_left && !zero_right)); // R1
endmodule

// File: tb/stereo_vol_ramp_tb.sv
module stereo_vol_ramp_tb;
    localparam int DATA_W = 24;
    localparam int LVL_W  = 10;
    localparam int ZF     = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_down = 1'b0, frame_stb = 1'b0;
    logic [DATA_W-1:0] left_in = '0, right_in = '0;
    logic [LVL_W-1:0]  req_left = '0, req_right = '0;
    logic mute_pin = 1'b0, mute_bit = 1'b0;
    logic [DATA_W-1:0] left_out, right_out;
    logic zero_left, zero_right;

    int errors = 0, checks = 0;
    int mlvl [2];
    int zcnt [2];
    logic [DATA_W-1:0] exp_out [2];

    always #10 clk = ~clk;

    stereo_vol_ramp #(.DATA_W(DATA_W), .LVL_W(LVL_W), .ZERO_FRAMES(ZF)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .frame_stb(frame_stb),
        .left_in(left_in), .right_in(right_in), .req_left(req_left),
        .req_right(req_right), .mute_pin(mute_pin), .mute_bit(mute_bit),
        .left_out(left_out), .right_out(right_out),
        .zero_left(zero_left), .zero_right(zero_right)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] scale(input logic [DATA_W-1:0] x, input int lvl);
        longint p;
        if (lvl == 1023) return x;
        p = longint'($signed(x)) * lvl;
        p = p >>> LVL_W;
        return p[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] pat(input int i, input int salt);
        case ((i + salt) % 7)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            2: return 24'hFFFFFF;
            3: return 24'h000001;
            default: return DATA_W'(i * 40503 + salt * 977 + 7);
        endcase
    endfunction

    // One frame: update model, strobe, compare all outputs
    task automatic frame(input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r,
                         input string tag, input bit chk_zero);
        int tgt;
        logic [DATA_W-1:0] ins [2];
        int rq [2];
        ins[0] = l; ins[1] = r; rq[0] = req_left; rq[1] = req_right;
        for (int c = 0; c < 2; c++) begin
            exp_out[c] = scale(ins[c], mlvl[c]);
            tgt = (mute_pin || mute_bit) ? 0 : rq[c];
            if (tgt > mlvl[c]) mlvl[c]++;
            else if (tgt < mlvl[c]) mlvl[c]--;
            if (ins[c] != 0) zcnt[c] = 0;
            else if (zcnt[c] < ZF + 1) zcnt[c]++;
        end
        @(negedge clk);
        left_in = l; right_in = r; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        chk({tag, " left"},  left_out,  exp_out[0]);
        chk({tag, " right"}, right_out, exp_out[1]);
        if (chk_zero) begin
            chk({tag, " zero_left"},  zero_left,  zcnt[0] > ZF);
            chk({tag, " zero_right"}, zero_right, zcnt[1] > ZF);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mlvl[0] = 0; mlvl[1] = 0; zcnt[0] = 0; zcnt[1] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset left", left_out, 0);
        chk("R1 reset right", right_out, 0);
        chk("R1 reset zl", zero_left, 0);
        chk("R1 reset zr", zero_right, 0);
        rst_n = 1'b1;

        // R9 R5 full ramp up through every code, R4 at the top
        req_left = 10'h3FF; req_right = 10'h3FF;
        for (int i = 0; i < 1023; i++) frame(pat(i, 0), pat(i, 3), "R5 R9 ramp up", 0);
        for (int i = 0; i < 14; i++) frame(pat(i, 1), pat(i, 5), "R4 unity", 1);

        // R3 request wiggle between strobes has no effect; R2 outputs hold
        @(negedge clk); req_left = 10'h000; req_right = 10'h001;
        repeat (4) @(negedge clk);
        chk("R2 hold left", left_out, exp_out[0]);
        chk("R2 hold right", right_out, exp_out[1]);
        req_left = 10'h3FF; req_right = 10'h3FF;
        frame(24'h7FFFFF, 24'h800000, "R3 withdrawn request", 1);

        // R9 independent channels ramp down to distinct levels
        req_left = 10'h200; req_right = 10'h010;
        for (int i = 0; i < 1100; i++) frame(pat(i, 2), pat(i, 4), "R9 R5 ramp down", 1);

        // R6 mute from pin, released mid ramp
        mute_pin = 1'b1;
        for (int i = 0; i < 40; i++) frame(pat(i, 6), pat(i, 1), "R6 mute pin", 1);
        mute_pin = 1'b0;
        for (int i = 0; i < 30; i++) frame(pat(i, 3), pat(i, 2), "R6 unmute", 1);
        // R6 mute from bit, held to level 0
        mute_bit = 1'b1;
        for (int i = 0; i < 600; i++) frame(pat(i, 5), pat(i, 0), "R6 mute bit", 1);
        chk("R6 muted left", left_out, 0);
        mute_bit = 1'b0;
        req_left = 10'h3FF; req_right = 10'h3FF;
        for (int i = 0; i < 1030; i++) frame(pat(i, 4), pat(i, 6), "R6 ramp back", 1);

        // R7 R8 zero flag threshold, saturation and clear
        for (int i = 0; i < 1024; i++) frame('0, pat(i, 1) | 24'h1, "R7 zeros", 0);
        chk("R7 at 1024 zeros", zero_left, 0);
        frame('0, 24'h5, "R7 1025th zero", 1);
        chk("R7 after 1025 zeros", zero_left, 1);
        for (int i = 0; i < 2500; i++) frame('0, 24'h3, "R8 saturate", 0);
        chk("R8 still high", zero_left, 1);
        frame(24'h000001, '0, "R7 clear", 1);
        chk("R7 cleared", zero_left, 0);

        // R1 soft power-down clears level, outputs, counts
        frame(24'h123456, 24'h654321, "R1 pre pd", 1);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        mlvl[0] = 0; mlvl[1] = 0; zcnt[0] = 0; zcnt[1] = 0;
        chk("R1 pd left", left_out, 0);
        chk("R1 pd right", right_out, 0);
        chk("R1 pd zr", zero_right, 0);
        frame(24'h7FFFFF, 24'h800000, "R1 level zero after pd", 1);
        for (int i = 0; i < 5; i++) frame(pat(i, 0), pat(i, 1), "R1 restart ramp", 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule